// File: doc/BRIEF.md
# User-Level Block Transfer Initiator

This block lets unprivileged code launch a copy of a contiguous run of words into a remote receive buffer. No system call and no descriptor ring are involved. Software makes two ordinary accesses to mapped windows. First it stores to the arm window. The store address is the destination in the proxy receive buffer, and the store data is the byte count. Then it loads from the start window. The load address is the source, and the load returns one status word that says whether the start was taken. When the load returns 0, software simply issues it again.

Once a transfer is accepted, the engine sends a header beat that carries the destination and the word count. It then fetches the source words, one at a time, over a memory read port with a fixed latency of one cycle, and forwards each word as a packet beat under valid/ready flow control. Transfers leave in the order they were started, and a new one begins only after the last beat of the previous one has been accepted.

This path gives no ordering guarantee against writes that other hardware propagates by snooping the memory bus. Address translation and protection are done before the block is reached.

Top module: `ubt_initiator`

## Requirements
- R1: After reset, `pkt_valid`, `mem_rd_en` and `host_rvalid` are 0, and a status load returns 0.
- R2: A store to window 0 with a byte count that is nonzero, a multiple of 4 and at most 4*MAX_WORDS, and an address whose low two bits are zero, records that address as the destination. It sets the armed flag (status bit 1) and clears the error flag (status bit 2).
- R3: A store to window 0 with any other byte count, or with a misaligned address, clears the armed flag and sets the error flag.
- R4: A load from window 1 made while the block is armed and idle, with a source address aligned to 4 bytes, returns 1. The armed flag clears and busy (status bit 0) becomes 1.
- R5: A load from window 1 made while the block is unarmed or busy returns 0. It starts no packet and leaves the armed flag as it was.
- R6: A load from window 1 made while the block is armed and idle, but with a source address whose low two bits are nonzero, returns 0, sets the error flag and keeps the armed flag.
- R7: An accepted transfer of N words emits N+1 beats. The first beat carries the destination in bits [AW-1:0] and N in the CW bits above them. It is followed by the words read from src, src+4, and so on up to src+4(N-1). `pkt_last` is 1 only on the final beat.
- R8: While `pkt_valid` is 1 and `pkt_ready` is 0, `pkt_valid`, `pkt_data` and `pkt_last` hold steady on the next cycle.
- R9: Busy stays 1 from acceptance until the final beat is taken, and is 0 in the cycle after that beat.
- R10: A store to window 0 made while busy arms the next transfer. Its packet follows the last beat of the current transfer once a later start load is accepted.
- R11: Every load returns its word with `host_rvalid` = 1 in the next cycle. A load from window 2 returns {err, armed, busy} in bits 2..0, and a start load returns its accept result in bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_req | input | 1 | Host access in this cycle |
| host_we | input | 1 | 1 = store, 0 = load |
| host_win | input | 2 | Window: 0 arm, 1 start, 2 status |
| host_addr | input | AW | Byte address inside the window (destination or source) |
| host_wdata | input | DW | Store data (byte count) |
| host_rvalid | output | 1 | Load response valid |
| host_rdata | output | DW | Load response word |
| mem_rd_en | output | 1 | Source read strobe |
| mem_rd_addr | output | AW | Source byte address |
| mem_rd_data | input | DW | Read data, one cycle after the strobe |
| pkt_valid | output | 1 | Packet beat valid |
| pkt_ready | input | 1 | Downstream accepts the beat |
| pkt_data | output | DW | Header or data word |
| pkt_last | output | 1 | Final beat of the packet |

## Verification
The bench builds the block with AW=16, DW=32 and MAX_WORDS=8, so CW is 4. The largest legal count is therefore 32 bytes, and counts of 32 and 36 bytes sit on either side of the length limit in a handful of cycles. It is cheap to run full-length packets under a stall pattern on `pkt_ready`, and to hold a transfer in flight long enough to probe the busy rejection and the re-arming done while busy.

// File: rtl/ubt_pkg.sv
package ubt_pkg;

    typedef enum logic [1:0] {
        WIN_ARM   = 2'd0,
        WIN_START = 2'd1,
        WIN_STAT  = 2'd2,
        WIN_NONE  = 2'd3
    } win_e;

    typedef enum logic [2:0] {
        ENG_IDLE = 3'd0,
        ENG_HDR  = 3'd1,
        ENG_RD   = 3'd2,
        ENG_LOAD = 3'd3,
        ENG_OUT  = 3'd4
    } eng_e;

    localparam int STAT_BUSY  = 0;
    localparam int STAT_ARMED = 1;
    localparam int STAT_ERR   = 2;

endpackage

// File: rtl/ubt_arm_regs.sv
module ubt_arm_regs #(
    parameter int AW        = 16,
    parameter int DW        = 32,
    parameter int MAX_WORDS = 256,
    parameter int CW        = $clog2(MAX_WORDS + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_bytes,
    input  logic          consume,
    input  logic          flag_err,
    output logic          armed,
    output logic          err,
    output logic [AW-1:0] dest,
    output logic [CW-1:0] words
);

    localparam logic [DW-1:0] MAX_BYTES = DW'(MAX_WORDS * 4);

    typedef struct packed {
        logic          armed;
        logic          err;
        logic [AW-1:0] dest;
        logic [CW-1:0] words;
    } arm_t;

    arm_t arm_d, arm_q;
    logic req_good;

    always_comb begin
        req_good = (wr_bytes != '0) && (wr_bytes[1:0] == 2'b00) &&
                   (wr_bytes <= MAX_BYTES) && (wr_addr[1:0] == 2'b00);
        arm_d = arm_q;
        if (wr_en) begin
            if (req_good) begin
                arm_d.armed = 1'b1;
                arm_d.err   = 1'b0;
                arm_d.dest  = wr_addr;
                arm_d.words = CW'(wr_bytes >> 2);
            end else begin
                arm_d.armed = 1'b0;
                arm_d.err   = 1'b1;
            end
        end else if (consume) begin
            arm_d.armed = 1'b0;
        end
        if (flag_err) begin
            arm_d.err = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            arm_q <= '0;
        end else begin
            arm_q <= arm_d;
        end
    end

    assign armed = arm_q.armed;
    assign err   = arm_q.err;
    assign dest  = arm_q.dest;
    assign words = arm_q.words;

    AST_CONSUME_DISARMS: assert property (@(posedge clk) disable iff (!rst_n)
        consume && !wr_en |=> !armed); // R4

    AST_BAD_STORE_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && (wr_bytes == '0) |=> err && !armed); // R3

    AST_GOOD_STORE_ARMS: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && (wr_bytes == DW'(4)) && (wr_addr[1:0] == 2'b00) |=> armed && !err && (words == CW'(1))); // R2

endmodule

// File: rtl/ubt_read_engine.sv
module ubt_read_engine
    import ubt_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 32,
    parameter int CW = 9
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [AW-1:0] start_src,
    input  logic [AW-1:0] start_dest,
    input  logic [CW-1:0] start_words,
    output logic          busy,
    output logic          mem_rd_en,
    output logic [AW-1:0] mem_rd_addr,
    input  logic [DW-1:0] mem_rd_data,
    output logic          pkt_valid,
    input  logic          pkt_ready,
    output logic [DW-1:0] pkt_data,
    output logic          pkt_last
);

    localparam logic [AW-1:0] WORD_STEP = AW'(4);
    localparam logic [CW-1:0] ONE_LEFT  = CW'(1);

    typedef struct packed {
        eng_e          state;
        logic [AW-1:0] addr;
        logic [CW-1:0] left;
        logic [DW-1:0] data;
    } eng_t;

    eng_t eng_d, eng_q;
    logic [DW-1:0] header;

    always_comb begin
        header = '0;
        header[AW-1:0]  = start_dest;
        header[AW +: CW] = start_words;
    end

    always_comb begin
        eng_d = eng_q;
        case (eng_q.state)
            ENG_IDLE: begin
                if (start) begin
                    eng_d.addr  = start_src;
                    eng_d.left  = start_words;
                    eng_d.data  = header;
                    eng_d.state = ENG_HDR;
                end
            end
            ENG_HDR: begin
                if (pkt_ready) begin
                    eng_d.state = ENG_RD;
                end
            end
            ENG_RD: begin
                eng_d.state = ENG_LOAD;
            end
            ENG_LOAD: begin
                eng_d.data  = mem_rd_data;
                eng_d.state = ENG_OUT;
            end
            ENG_OUT: begin
                if (pkt_ready) begin
                    if (eng_q.left == ONE_LEFT) begin
                        eng_d.left  = '0;
                        eng_d.state = ENG_IDLE;
                    end else begin
                        eng_d.left  = eng_q.left - ONE_LEFT;
                        eng_d.addr  = eng_q.addr + WORD_STEP;
                        eng_d.state = ENG_RD;
                    end
                end
            end
            default: begin
                eng_d.state = ENG_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            eng_q <= '{state: ENG_IDLE, addr: '0, left: '0, data: '0};
        end else begin
            eng_q <= eng_d;
        end
    end

    assign busy        = (eng_q.state != ENG_IDLE);
    assign mem_rd_en   = (eng_q.state == ENG_RD);
    assign mem_rd_addr = eng_q.addr;
    assign pkt_valid   = (eng_q.state == ENG_HDR) || (eng_q.state == ENG_OUT);
    assign pkt_data    = eng_q.data;
    assign pkt_last    = (eng_q.state == ENG_OUT) && (eng_q.left == ONE_LEFT);

    AST_PKT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_valid && !pkt_ready |=> pkt_valid && $stable(pkt_data) && $stable(pkt_last)); // R8

    AST_BUSY_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_valid && pkt_ready && pkt_last |=> !busy); // R9

    AST_START_ONLY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> !busy); // R10

    AST_SINGLE_READ: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_en |=> !mem_rd_en && !pkt_valid); // R7

endmodule

// File: rtl/ubt_initiator.sv
module ubt_initiator
    import ubt_pkg::*;
#(
    parameter int AW        = 16,
    parameter int DW        = 32,
    parameter int MAX_WORDS = 256
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          host_req,
    input  logic          host_we,
    input  logic [1:0]    host_win,
    input  logic [AW-1:0] host_addr,
    input  logic [DW-1:0] host_wdata,
    output logic          host_rvalid,
    output logic [DW-1:0] host_rdata,
    output logic          mem_rd_en,
    output logic [AW-1:0] mem_rd_addr,
    input  logic [DW-1:0] mem_rd_data,
    output logic          pkt_valid,
    input  logic          pkt_ready,
    output logic [DW-1:0] pkt_data,
    output logic          pkt_last
);

    localparam int CW = $clog2(MAX_WORDS + 1);

    typedef struct packed {
        logic          rvalid;
        logic [DW-1:0] rdata;
    } resp_t;

    resp_t resp_d, resp_q;

    logic          is_arm, is_start, is_stat, src_ok;
    logic          accept, bad_src;
    logic          armed, err, busy;
    logic [AW-1:0] dest;
    logic [CW-1:0] words;

    always_comb begin
        is_arm   = host_req &&  host_we && (host_win == WIN_ARM);
        is_start = host_req && !host_we && (host_win == WIN_START);
        is_stat  = host_req && !host_we && (host_win == WIN_STAT);
        src_ok   = (host_addr[1:0] == 2'b00);
        accept   = is_start && armed && !busy &&  src_ok;
        bad_src  = is_start && armed && !busy && !src_ok;
    end

    always_comb begin
        resp_d        = '0;
        resp_d.rvalid = host_req && !host_we;
        if (is_start) begin
            resp_d.rdata[0] = accept;
        end
        if (is_stat) begin
            resp_d.rdata[STAT_BUSY]  = busy;
            resp_d.rdata[STAT_ARMED] = armed;
            resp_d.rdata[STAT_ERR]   = err;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            resp_q <= '0;
        end else begin
            resp_q <= resp_d;
        end
    end

    assign host_rvalid = resp_q.rvalid;
    assign host_rdata  = resp_q.rdata;

    ubt_arm_regs #(
        .AW(AW), .DW(DW), .MAX_WORDS(MAX_WORDS), .CW(CW)
    ) u_arm (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (is_arm),
        .wr_addr  (host_addr),
        .wr_bytes (host_wdata),
        .consume  (accept),
        .flag_err (bad_src),
        .armed    (armed),
        .err      (err),
        .dest     (dest),
        .words    (words)
    );

    ubt_read_engine #(
        .AW(AW), .DW(DW), .CW(CW)
    ) u_eng (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (accept),
        .start_src   (host_addr),
        .start_dest  (dest),
        .start_words (words),
        .busy        (busy),
        .mem_rd_en   (mem_rd_en),
        .mem_rd_addr (mem_rd_addr),
        .mem_rd_data (mem_rd_data),
        .pkt_valid   (pkt_valid),
        .pkt_ready   (pkt_ready),
        .pkt_data    (pkt_data),
        .pkt_last    (pkt_last)
    );

    AST_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> busy && pkt_valid && !armed); // R4

    AST_REJECT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        is_start && !busy && !accept |=> !busy && !pkt_valid); // R5

    AST_RESP_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
        host_req && !host_we |=> host_rvalid); // R11

    AST_BAD_SRC_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        bad_src |=> err && armed && !busy); // R6

endmodule

// File: tb/ubt_initiator_test.sv
`timescale 1ns/1ps
module ubt_initiator_test;

    localparam int AW = 16;
    localparam int DW = 32;
    localparam int MW = 8;

    typedef struct packed {
        logic [15:0] dest;
        logic [31:0] bytes;
        logic [15:0] src;
        logic        ok;
    } vec_t;

    localparam int NV = 8;
    localparam vec_t VECS [NV] = '{
        '{dest: 16'h0100, bytes: 32'd4,  src: 16'h0040, ok: 1'b1},
        '{dest: 16'h2000, bytes: 32'd32, src: 16'h1000, ok: 1'b1},
        '{dest: 16'h0010, bytes: 32'd12, src: 16'h0FFC, ok: 1'b1},
        '{dest: 16'h0020, bytes: 32'd0,  src: 16'h0080, ok: 1'b0},
        '{dest: 16'h0020, bytes: 32'd6,  src: 16'h0080, ok: 1'b0},
        '{dest: 16'h0020, bytes: 32'd36, src: 16'h0080, ok: 1'b0},
        '{dest: 16'h0022, bytes: 32'd8,  src: 16'h0080, ok: 1'b0},
        '{dest: 16'h3000, bytes: 32'd20, src: 16'h0500, ok: 1'b1}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          host_req = 1'b0;
    logic          host_we = 1'b0;
    logic [1:0]    host_win = 2'd3;
    logic [AW-1:0] host_addr = '0;
    logic [DW-1:0] host_wdata = '0;
    logic          host_rvalid;
    logic [DW-1:0] host_rdata;
    logic          mem_rd_en;
    logic [AW-1:0] mem_rd_addr;
    logic [DW-1:0] mem_rd_data = '0;
    logic          pkt_valid;
    logic          pkt_ready = 1'b0;
    logic [DW-1:0] pkt_data;
    logic          pkt_last;

    int n_chk = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    ubt_initiator #(.AW(AW), .DW(DW), .MAX_WORDS(MW)) uut (
        .clk(clk), .rst_n(rst_n),
        .host_req(host_req), .host_we(host_we), .host_win(host_win),
        .host_addr(host_addr), .host_wdata(host_wdata),
        .host_rvalid(host_rvalid), .host_rdata(host_rdata),
        .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr), .mem_rd_data(mem_rd_data),
        .pkt_valid(pkt_valid), .pkt_ready(pkt_ready),
        .pkt_data(pkt_data), .pkt_last(pkt_last)
    );

    function automatic logic [31:0] pat(logic [15:0] a);
        return {a ^ 16'h5A5A, a};
    endfunction

    function automatic logic [31:0] hdr(logic [15:0] d, int n);
        return (32'(n) << 16) | {16'h0, d};
    endfunction

    // memory model with one cycle of read latency
    always_ff @(posedge clk) begin
        if (mem_rd_en) mem_rd_data <= pat(mem_rd_addr);
    end

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic store_arm(logic [15:0] d, logic [31:0] b);
        @(negedge clk);
        host_req = 1'b1; host_we = 1'b1; host_win = 2'd0;
        host_addr = d; host_wdata = b;
        @(negedge clk);
        host_req = 1'b0; host_we = 1'b0; host_win = 2'd3;
    endtask

    task automatic load(logic [1:0] w, logic [15:0] a, string req, logic [31:0] exp);
        @(negedge clk);
        host_req = 1'b1; host_we = 1'b0; host_win = w; host_addr = a;
        @(negedge clk);
        host_req = 1'b0; host_win = 2'd3;
        chk({req, " rvalid (R11)"}, 32'(host_rvalid), 32'd1);
        chk(req, host_rdata, exp);
    endtask

    task automatic quiet(string req);
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            chk(req, {31'd0, pkt_valid}, 32'd0);
        end
    endtask

    task automatic collect(logic [15:0] d, logic [15:0] s, int n);
        int idx = 0;
        int guard = 0;
        bit stalled = 1'b0;
        logic [31:0] prev = '0;
        logic [31:0] exp;
        bit r;
        while (idx < n + 1 && guard < 400) begin
            @(negedge clk);
            if (stalled) begin
                chk("R8 held valid", 32'(pkt_valid), 32'd1);
                chk("R8 held data", pkt_data, prev);
            end
            r = (guard % 3) != 2;
            pkt_ready = r;
            if (pkt_valid && r) begin
                exp = (idx == 0) ? hdr(d, n) : pat(s + 16'(4 * (idx - 1)));
                chk("R7 beat data", pkt_data, exp);
                chk("R7 last flag", 32'(pkt_last), 32'(idx == n));
                idx++;
                stalled = 1'b0;
            end else if (pkt_valid) begin
                stalled = 1'b1;
                prev = pkt_data;
            end else begin
                stalled = 1'b0;
            end
            guard++;
        end
        if (guard >= 400) chk("R7 packet completes", 32'(idx), 32'(n + 1));
        @(negedge clk);
        pkt_ready = 1'b0;
    endtask

    initial begin
        #(5.0 * 150000);
        n_bad++;
        $display("FAIL watchdog: actual running expected finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 pkt_valid", 32'(pkt_valid), 32'd0);
        chk("R1 mem_rd_en", 32'(mem_rd_en), 32'd0);
        chk("R1 rvalid", 32'(host_rvalid), 32'd0);
        rst_n = 1'b1;
        load(2'd2, 16'h0, "R1 status after reset", 32'd0);

        // start with nothing captured
        load(2'd1, 16'h0040, "R5 unarmed start", 32'd0);
        quiet("R5 no packet when unarmed");

        for (int i = 0; i < NV; i++) begin
            store_arm(VECS[i].dest, VECS[i].bytes);
            load(2'd2, 16'h0, VECS[i].ok ? "R2 armed status" : "R3 rejected status",
                 VECS[i].ok ? 32'd2 : 32'd4);
            load(2'd1, VECS[i].src, VECS[i].ok ? "R4 accepted start" : "R5 start after bad store",
                 32'(VECS[i].ok));
            if (VECS[i].ok) begin
                load(2'd2, 16'h0, "R9 busy in flight", 32'd1);
                collect(VECS[i].dest, VECS[i].src, int'(VECS[i].bytes) / 4);
                load(2'd2, 16'h0, "R9 idle after last", 32'd0);
            end else begin
                quiet("R5 no packet after bad store");
            end
        end

        // misaligned source
        store_arm(16'h0400, 32'd8);
        load(2'd1, 16'h0202, "R6 misaligned src start", 32'd0);
        load(2'd2, 16'h0, "R6 err set armed kept", 32'd6);
        load(2'd1, 16'h0200, "R4 retry aligned", 32'd1);
        collect(16'h0400, 16'h0200, 2);
        load(2'd2, 16'h0, "R6 err persists", 32'd4);

        // busy rejection and re-arm while busy
        store_arm(16'h0600, 32'd8);
        load(2'd1, 16'h0300, "R4 first start", 32'd1);
        store_arm(16'h0700, 32'd12);
        load(2'd2, 16'h0, "R10 armed while busy", 32'd3);
        load(2'd1, 16'h0310, "R5 start while busy", 32'd0);
        load(2'd2, 16'h0, "R5 armed unchanged", 32'd3);
        collect(16'h0600, 16'h0300, 2);
        load(2'd1, 16'h0310, "R10 second start", 32'd1);
        collect(16'h0700, 16'h0310, 3);
        load(2'd2, 16'h0, "R10 idle at end", 32'd0);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule